// File: doc/BRIEF.md
# Push-Pull Sign-Magnitude PWM Output

This block turns a signed audio sample into a pair of pulse-width-modulated outputs meant to drive a loudspeaker directly across its two terminals. Each sample is a two's-complement word. The block splits it into a polarity and a magnitude. The polarity picks which of the two outputs pulses. The magnitude sets how many clock cycles that output stays high at the start of each period. The other output is held low for the whole period.

The period length, in clock cycles, is programmable. The block samples both the audio word and the period length once per period, on the last cycle of the period. It raises a one-cycle strobe on that cycle so that an upstream source can present the next sample. When the polarity flips from one period to the next, both outputs stay low for the first cycle of the new period. This dead time prevents the two outputs from overlapping. A synchronous enable freezes the block and holds both outputs low.

Top module: `pwm_pushpull`

## Requirements
- R1: During reset and on the first cycle after reset, both pulse outputs are low.
- R2: A sample whose top bit is 0 and whose magnitude is non-zero produces pulses only on `drv_pos_o`. `drv_neg_o` stays low for that whole period.
- R3: A sample whose top bit is 1 produces pulses only on `drv_neg_o`. `drv_pos_o` stays low for that whole period.
- R4: The magnitude is the absolute value of the two's-complement sample. The most negative code (-512 with 10 bits) saturates to 511. A sample of zero leaves both outputs low for the whole period.
- R5: Counting period cycles from 0, the active output is high on cycle c exactly when c is less than the magnitude. A latched period value P gives a period of P cycles. A value of 0 behaves as 1.
- R6: `frame_end_o` is high on the last cycle of every period, and only while enabled. The sample and period inputs are taken only at the clock edge that ends such a cycle. Changes at any other time have no effect.
- R7: When the latched polarity differs from that of the previous period, both outputs are low on cycle 0 of the new period.
- R8: `drv_pos_o` and `drv_neg_o` are never high in the same cycle.
- R9: While `en_i` is low, both outputs and `frame_end_o` are low and the period position does not advance. Counting resumes from the same position when `en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Synchronous run enable |
| sample_i | input | SAMPLE_W (10) | Two's-complement audio sample |
| period_i | input | PER_W (10) | Period length in clock cycles |
| drv_pos_o | output | 1 | Pulse output for non-negative samples |
| drv_neg_o | output | 1 | Pulse output for negative samples |
| frame_end_o | output | 1 | One-cycle strobe on the last cycle of a period |

## Verification
The assertions assume that `en_i`, `sample_i` and `period_i` change only between clock edges. They also assume that reset is held for at least one edge before checking starts. Beyond that, the properties accept any sample or period value, including a period of zero. The stimulus changes every input at falling edges. It sweeps all 1024 sample codes with a short period, then uses periods longer than the full magnitude. In one section it randomizes the inputs on every cycle. It also toggles the enable at arbitrary points, so the properties are exercised at every position in a period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;
endpackage

// File: rtl/pwm_sm_split.sv
module pwm_sm_split #(
    parameter int SAMPLE_W = 10,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output pwm_pkg::pol_e       pol_o,
    output logic [MAG_W-1:0]    mag_o
);
    logic [SAMPLE_W-1:0] abs_w;

    always_comb begin
        pol_o = sample_i[SAMPLE_W-1] ? pwm_pkg::POL_NEG : pwm_pkg::POL_POS;
        abs_w = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
        if (abs_w[SAMPLE_W-1]) begin
            mag_o = {MAG_W{1'b1}};
        end else begin
            mag_o = abs_w[MAG_W-1:0];
        end
    end

    always_comb begin
        assert_sat_R4: assert (mag_o != '0 || sample_i == '0);
    end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    output logic [PER_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [PER_W-1:0] last_w;

    always_comb begin
        last_w = (st_q.per == '0) ? '0 : st_q.per - 1'b1;
        wrap_o = en_i && (st_q.cnt == last_w);
        st_d   = st_q;
        if (en_i) begin
            if (wrap_o) begin
                st_d.cnt = '0;
                st_d.per = period_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_w);
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q.cnt));
    assert_per_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(st_q.per));
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
    parameter int MAG_W = 9,
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             load_i,
    input  pwm_pkg::pol_e    pol_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [PER_W-1:0] cnt_i,
    output logic             pos_o,
    output logic             neg_o
);
    import pwm_pkg::*;

    localparam int CMP_W = (MAG_W > PER_W) ? MAG_W : PER_W;

    typedef struct packed {
        pol_e             pol;
        logic [MAG_W-1:0] mag;
        logic             dead;
    } steer_t;

    steer_t     st_d, st_q;
    logic       active_w;
    logic [CMP_W-1:0] mag_x, cnt_x;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pol  = pol_i;
            st_d.mag  = mag_i;
            st_d.dead = (pol_i != st_q.pol);
        end
        mag_x    = CMP_W'(st_q.mag);
        cnt_x    = CMP_W'(cnt_i);
        active_w = en_i && (mag_x > cnt_x) && !(st_q.dead && cnt_i == '0);
        pos_o    = active_w && (st_q.pol == POL_POS);
        neg_o    = active_w && (st_q.pol == POL_NEG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pol: POL_POS, mag: '0, dead: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_o && neg_o));
    assert_dead_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && pol_i != st_q.pol) |=> (!pos_o && !neg_o));
    assert_mag_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.mag));
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!pos_o && !neg_o));
endmodule

// File: rtl/pwm_pushpull.sv
module pwm_pushpull #(
    parameter int SAMPLE_W = 10,
    parameter int PER_W    = 10,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [PER_W-1:0]    period_i,
    output logic                drv_pos_o,
    output logic                drv_neg_o,
    output logic                frame_end_o
);
    pwm_pkg::pol_e    pol_w;
    logic [MAG_W-1:0] mag_w;
    logic [PER_W-1:0] cnt_w;
    logic             wrap_w;

    pwm_sm_split #(.SAMPLE_W(SAMPLE_W)) u_split (
        .sample_i (sample_i),
        .pol_o    (pol_w),
        .mag_o    (mag_w)
    );

    pwm_period_ctr #(.PER_W(PER_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .cnt_o    (cnt_w),
        .wrap_o   (wrap_w)
    );

    pwm_steer #(.MAG_W(MAG_W), .PER_W(PER_W)) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .load_i (wrap_w),
        .pol_i  (pol_w),
        .mag_i  (mag_w),
        .cnt_i  (cnt_w),
        .pos_o  (drv_pos_o),
        .neg_o  (drv_neg_o)
    );

    assign frame_end_o = wrap_w;

    assert_first_cycle_low_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!drv_pos_o && !drv_neg_o));
endmodule

// File: tb/pwm_pushpull_bench.sv
module pwm_pushpull_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [9:0] sample = '0;
    logic [9:0] period = '0;
    logic       pos, neg, fend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state derived from the requirements
    int m_cnt = 0, m_per = 0, m_mag = 0, m_sign = 0, m_dead = 0, m_en = 0;
    logic [31:0] lfsr = 32'hACE1_2345;

    always #10 clk = ~clk;

    pwm_pushpull u_pwm_pushpull (
        .clk(clk), .rst_n(rst_n), .en_i(en), .sample_i(sample),
        .period_i(period), .drv_pos_o(pos), .drv_neg_o(neg), .frame_end_o(fend)
    );

    function automatic int mag_of(input logic [9:0] s);
        int v = int'($signed(s));
        if (v < 0) v = -v;
        return (v > 511) ? 511 : v;
    endfunction

    function automatic int last_of(input int p);
        return (p == 0) ? 0 : p - 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cnt=%0d mag=%0d)", tag, act, exp, m_cnt, m_mag);
        end
    endtask

    task automatic check_now();
        int e_end, e_act, e_pos, e_neg;
        string tag;
        e_end = (m_en != 0 && m_cnt == last_of(m_per)) ? 1 : 0;
        e_act = (m_en != 0 && m_mag > m_cnt && !(m_dead != 0 && m_cnt == 0)) ? 1 : 0;
        e_pos = (e_act != 0 && m_sign == 0) ? 1 : 0;
        e_neg = (e_act != 0 && m_sign == 1) ? 1 : 0;
        if (m_en == 0)                       tag = "R9";
        else if (m_dead != 0 && m_cnt == 0) tag = "R7";
        else if (m_mag == 0)                tag = "R4";
        else if (m_sign == 1)               tag = "R3";
        else                                 tag = "R2";
        chk({tag, "/R5 pos"}, int'(pos), e_pos);
        chk({tag, "/R5 neg"}, int'(neg), e_neg);
        chk("R6 frame_end", int'(fend), e_end);
        chk("R8 overlap", int'(pos && neg), 0);
    endtask

    // check outputs, apply new inputs, advance reference across the next edge
    task automatic tick(input logic e, input logic [9:0] s, input logic [9:0] p);
        int nsign;
        check_now();
        en = e; sample = s; period = p;
        if (e) begin
            if (m_cnt == last_of(m_per)) begin
                nsign  = s[9] ? 1 : 0;
                m_dead = (nsign != m_sign) ? 1 : 0;
                m_sign = nsign;
                m_mag  = mag_of(s);
                m_per  = int'(p);
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
        end
        m_en = e ? 1 : 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pos in reset", int'(pos), 0);
        chk("R1 neg in reset", int'(neg), 0);
        rst_n = 1'b1;
        m_en = 0;
        chk("R1 pos after reset", int'(pos), 0);
        chk("R1 neg after reset", int'(neg), 0);

        // R4 saturation and sign split at unit arithmetic
        chk("R4 mag of -512", mag_of(10'h200), 511);

        // exhaustive sample sweep, short period
        for (int s = 0; s < 1024; s++)
            for (int k = 0; k < 8; k++) tick(1'b1, 10'(s), 10'd8);

        // long periods: full width visible, sign swaps, saturation
        begin
            logic [9:0] pats [8] = '{10'h200, 10'h1FF, 10'h3FF, 10'h001,
                                     10'h000, 10'h0FF, 10'h300, 10'h100};
            for (int i = 0; i < 8; i++)
                for (int k = 0; k < 530; k++) tick(1'b1, pats[i], 10'd520);
        end

        // R5 period value 0 and 1 (one-cycle periods)
        for (int k = 0; k < 12; k++) tick(1'b1, (k % 2) ? 10'h3FE : 10'h002, 10'd0);
        for (int k = 0; k < 12; k++) tick(1'b1, 10'h005, 10'd1);

        // R6/R9: inputs scrambled every cycle, enable dropped at random
        for (int k = 0; k < 6000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            tick(lfsr[7:0] != 8'h00 && lfsr[3:0] != 4'h5, lfsr[17:8],
                 10'(20 + (lfsr[27:22] % 40)));
        end

        // R9 long disable then resume
        for (int k = 0; k < 20; k++) tick(1'b0, 10'h155, 10'd30);
        for (int k = 0; k < 80; k++) tick(1'b1, 10'h2AA, 10'd30);

        check_now();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule